// File: doc/BRIEF.md
# Address-Masked GPIO Port

This block is an eight-pin general-purpose I/O port behind a small synchronous register bus. A single data register is visible throughout the low 1 KB of the block's address space. The byte-address bits just above the word offset act as a per-pin mask, so software can set or clear any group of pins with one store and no read-modify-write. A read through the same window returns only the pins its mask selects.

A direction register chooses, pin by pin, whether the port drives the pad or listens to it. Pad inputs cross into the clock domain through a two-flop synchronizer. A read of the data window returns the output register bit for driven pins and the synchronized pad value for pins that are inputs. Read data is registered, so it appears one clock after the address is presented.

Top module: `maskGpioPort`

## Requirements
- R1: While reset is asserted and right after it, padOe is 0x00 (all pins inputs), padOut is 0x00 and busRdData is 0x00.
- R2: Every byte address from 0x000 to 0x3FF reaches the data register. Pin n is selected by address bit 2+n. Address bits 1:0 and bits 11:10 equal to zero do not change the mask.
- R3: A data-window read returns the pin value on each bit whose mask bit is 1 and returns 0 on each bit whose mask bit is 0. A read with mask 0x00 returns 0x00.
- R4: A data-window write loads the write-data bit into each output register bit whose mask bit is 1 and leaves every other bit unchanged. A write with mask 0x00 changes nothing. padOut always shows the output register.
- R5: Address 0x400 holds the direction register. A write there loads all eight bits, where 1 means output and 0 means input. padOe shows this register, and a read of 0x400 returns it.
- R6: In a data-window read, a pin whose direction bit is 1 returns its output register bit, and a pin whose direction bit is 0 returns its synchronized pad value.
- R7: A pad change driven before clock edge k first shows in a data-window read as busRdData after edge k+2, through two synchronizer flops and the read register. It is not visible after edge k+1.
- R8: A data-window write updates output register bits even for pins configured as inputs. That value is driven as soon as the pin becomes an output.
- R9: Writes to 0x404 and to any other address outside 0x000 to 0x400 leave padOut and padOe unchanged, and reads there return 0x00.
- R10: busRdData is loaded at each clock edge from the address and state present before that edge. A read and a write in the same cycle therefore return the value from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| busAddr | input | 12 | Byte address |
| busWrEn | input | 1 | Write strobe for the current cycle |
| busWrData | input | 8 | Write data |
| busRdData | output | 8 | Registered read data for the previous cycle's address |
| padIn | input | 8 | Asynchronous pad inputs |
| padOut | output | 8 | Output register value driven to the pads |
| padOe | output | 8 | Per-pin output enable (direction register) |

## Verification
A write and a read of the data window always fall in the same cycle, because each bus cycle carries one address that drives both the read mux and the write path. The bench issues write cycles with full and partial masks and checks that the read data returned with them holds the pre-write pin values. It then checks the new value on padOut at the same sample. A second overlap arises when a pad transition is still in the synchronizer while a masked read samples it. The bench changes the pads while issuing back-to-back reads and checks that the new value appears after exactly the third edge.

// File: rtl/maskGpioPkg.sv
package maskGpioPkg;
  typedef enum logic [1:0] {
    RD_NONE = 2'd0,
    RD_DATA = 2'd1,
    RD_DIR  = 2'd2
  } rdSrc_e;

  typedef struct packed {
    logic   dataWr;
    logic   dirWr;
    rdSrc_e rdSrc;
  } ctrlStrobe_t;
endpackage

// File: rtl/maskGpioCtrl.sv
module maskGpioCtrl
  import maskGpioPkg::*;
#(
  parameter int ADDR_W      = 12,
  parameter int PINS        = 8,
  parameter int WINDOW_LOG2 = 10,
  parameter int DIR_OFFSET  = 'h400
) (
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  output ctrlStrobe_t       strobe,
  output logic [PINS-1:0]   laneMask
);
  localparam logic [ADDR_W-1:0] DIR_ADDR = ADDR_W'(DIR_OFFSET);
  localparam int HI_W = ADDR_W - WINDOW_LOG2;

  logic inWindow;
  logic atDir;

  assign inWindow = (busAddr[ADDR_W-1:WINDOW_LOG2] == HI_W'(0));
  assign atDir    = (busAddr == DIR_ADDR);
  assign laneMask = busAddr[2 +: PINS];

  always_comb begin
    strobe.dataWr = busWrEn && inWindow;
    strobe.dirWr  = busWrEn && atDir;
    if (inWindow)   strobe.rdSrc = RD_DATA;
    else if (atDir) strobe.rdSrc = RD_DIR;
    else            strobe.rdSrc = RD_NONE;
  end
endmodule

// File: rtl/maskGpioDatapath.sv
module maskGpioDatapath
  import maskGpioPkg::*;
#(
  parameter int PINS        = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            rstN,
  input  ctrlStrobe_t     strobe,
  input  logic [PINS-1:0] laneMask,
  input  logic [PINS-1:0] wrData,
  input  logic [PINS-1:0] padIn,
  output logic [PINS-1:0] padOut,
  output logic [PINS-1:0] padOe,
  output logic [PINS-1:0] rdData
);
  localparam int LAST = SYNC_STAGES - 1;

  logic [PINS-1:0] outReg;
  logic [PINS-1:0] dirReg;
  logic [PINS-1:0] syncPipe [SYNC_STAGES];
  logic [PINS-1:0] pinView;
  logic [PINS-1:0] rdNext;

  // Synchronizer chain; the first stage samples the pads
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncPipe[0] <= '0;
    else       syncPipe[0] <= padIn;
  end

  generate
    for (genvar s = 1; s < SYNC_STAGES; s++) begin : gSync
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncPipe[s] <= '0;
        else       syncPipe[s] <= syncPipe[s-1];
      end
    end
  endgenerate

  // Masked update: only lanes selected by the address change
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outReg <= '0;
      dirReg <= '0;
    end else begin
      if (strobe.dataWr) outReg <= (outReg & ~laneMask) | (wrData & laneMask);
      if (strobe.dirWr)  dirReg <= wrData;
    end
  end

  assign pinView = (dirReg & outReg) | (~dirReg & syncPipe[LAST]);

  always_comb begin
    unique case (strobe.rdSrc)
      RD_DATA: rdNext = pinView & laneMask;
      RD_DIR:  rdNext = dirReg;
      default: rdNext = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rdData <= '0;
    else       rdData <= rdNext;
  end

  assign padOut = outReg;
  assign padOe  = dirReg;
endmodule

// File: rtl/maskGpioPort.sv
module maskGpioPort
  import maskGpioPkg::*;
#(
  parameter int ADDR_W      = 12,
  parameter int PINS        = 8,
  parameter int WINDOW_LOG2 = 10,
  parameter int DIR_OFFSET  = 'h400,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic [PINS-1:0]   busWrData,
  output logic [PINS-1:0]   busRdData,
  input  logic [PINS-1:0]   padIn,
  output logic [PINS-1:0]   padOut,
  output logic [PINS-1:0]   padOe
);
  ctrlStrobe_t     strobe;
  logic [PINS-1:0] laneMask;

  maskGpioCtrl #(
    .ADDR_W(ADDR_W), .PINS(PINS), .WINDOW_LOG2(WINDOW_LOG2), .DIR_OFFSET(DIR_OFFSET)
  ) uCtrl (
    .busAddr (busAddr),
    .busWrEn (busWrEn),
    .strobe  (strobe),
    .laneMask(laneMask)
  );

  maskGpioDatapath #(
    .PINS(PINS), .SYNC_STAGES(SYNC_STAGES)
  ) uPath (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .laneMask(laneMask),
    .wrData  (busWrData),
    .padIn   (padIn),
    .padOut  (padOut),
    .padOe   (padOe),
    .rdData  (busRdData)
  );
endmodule

// File: rtl/maskGpioPort_chk.sv
module maskGpioPort_chk #(
  parameter int ADDR_W      = 12,
  parameter int PINS        = 8,
  parameter int WINDOW_LOG2 = 10,
  parameter int DIR_OFFSET  = 'h400
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] busAddr,
  input logic              busWrEn,
  input logic [PINS-1:0]   busWrData,
  input logic [PINS-1:0]   busRdData,
  input logic [PINS-1:0]   padOut,
  input logic [PINS-1:0]   padOe
);
  localparam int HI_W = ADDR_W - WINDOW_LOG2;

  logic            inWin;
  logic            atDir;
  logic            outside;
  logic [PINS-1:0] mask;

  assign inWin   = (busAddr[ADDR_W-1:WINDOW_LOG2] == HI_W'(0));
  assign atDir   = (busAddr == ADDR_W'(DIR_OFFSET));
  assign outside = !inWin && !atDir;
  assign mask    = busAddr[2 +: PINS];

  // R1
  a_r1_reset_state: assert property (@(posedge clk)
    !rstN |=> (padOut == '0 && padOe == '0 && busRdData == '0));

  // R4
  a_r4_masked_write: assert property (@(posedge clk) disable iff (!rstN)
    (inWin && busWrEn) |=>
      padOut == (($past(padOut) & ~$past(mask)) | ($past(busWrData) & $past(mask))));

  // R3
  a_r3_unmasked_zero: assert property (@(posedge clk) disable iff (!rstN)
    inWin |=> ((busRdData & ~$past(mask)) == '0));

  // R6
  a_r6_output_readback: assert property (@(posedge clk) disable iff (!rstN)
    inWin |=> (((busRdData ^ $past(padOut)) & $past(mask & padOe)) == '0));

  // R5
  a_r5_dir_write: assert property (@(posedge clk) disable iff (!rstN)
    (atDir && busWrEn) |=> (padOe == $past(busWrData)));

  // R5, R10
  a_r5_dir_read: assert property (@(posedge clk) disable iff (!rstN)
    atDir |=> (busRdData == $past(padOe)));

  // R9
  a_r9_outside_inert: assert property (@(posedge clk) disable iff (!rstN)
    outside |=> ($stable(padOut) && $stable(padOe) && busRdData == '0));
endmodule

bind maskGpioPort maskGpioPort_chk #(
  .ADDR_W(ADDR_W), .PINS(PINS), .WINDOW_LOG2(WINDOW_LOG2), .DIR_OFFSET(DIR_OFFSET)
) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .busAddr  (busAddr),
  .busWrEn  (busWrEn),
  .busWrData(busWrData),
  .busRdData(busRdData),
  .padOut   (padOut),
  .padOe    (padOe)
);

// File: tb/sim_maskGpioPort.sv
module sim_maskGpioPort;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [11:0] busAddr = 12'h800;
  logic        busWrEn = 1'b0;
  logic [7:0]  busWrData = '0;
  logic [7:0]  busRdData;
  logic [7:0]  padIn = '0;
  logic [7:0]  padOut;
  logic [7:0]  padOe;

  always #5 clk = ~clk;

  maskGpioPort u0 (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busWrData(busWrData), .busRdData(busRdData), .padIn(padIn),
    .padOut(padOut), .padOe(padOe)
  );

  typedef struct {
    logic [7:0] rd;
    logic [7:0] out;
    logic [7:0] oe;
    string      req;
  } exp_t;

  exp_t sbq[$];
  exp_t monItem;
  int   checkCount = 0;
  int   failCount  = 0;
  bit   finished   = 1'b0;

  // Reference state from the requirements
  logic [7:0] mOut = '0;
  logic [7:0] mDir = '0;
  logic [7:0] p1 = '0;
  logic [7:0] p2 = '0;
  logic [7:0] padDrive = '0;

  task automatic compare(input logic [7:0] act, input logic [7:0] exp, input string what, input string req);
    checkCount++;
    if (act !== exp) begin
      failCount++;
      $display("FAIL %s %s: actual 0x%02h expected 0x%02h at %0t", req, what, act, exp, $time);
    end
  endtask

  // Driver: one bus cycle, expected outcome pushed once the edge has passed
  task automatic busCycle(input logic [11:0] a, input logic we, input logic [7:0] wd, input string req);
    logic [7:0] m;
    logic [7:0] er;
    @(negedge clk);
    busAddr = a; busWrEn = we; busWrData = wd; padIn = padDrive;
    m = a[9:2];
    if (a[11:10] == 2'b00)  er = m & ((mDir & mOut) | (~mDir & p2));
    else if (a == 12'h400)  er = mDir;
    else                    er = 8'h00;
    if (we) begin
      if (a[11:10] == 2'b00) mOut = (mOut & ~m) | (wd & m);
      else if (a == 12'h400) mDir = wd;
    end
    @(posedge clk);
    p2 = p1; p1 = padIn;
    #1;
    sbq.push_back('{er, mOut, mDir, req});
  endtask

  // Monitor: compares everything queued since the last falling edge
  always @(negedge clk) begin
    while (sbq.size() > 0) begin
      monItem = sbq.pop_front();
      compare(busRdData, monItem.rd,  "busRdData", monItem.req);
      compare(padOut,    monItem.out, "padOut",    monItem.req);
      compare(padOe,     monItem.oe,  "padOe",     monItem.req);
    end
  end

  task automatic finishRun();
    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checkCount, failCount);
      $finish;
    end
  endtask

  initial begin
    #200000;
    checkCount++;
    failCount++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    // R1: reset state
    repeat (3) @(posedge clk);
    @(negedge clk);
    compare(padOe, 8'h00, "padOe in reset", "R1");
    compare(padOut, 8'h00, "padOut in reset", "R1");
    compare(busRdData, 8'h00, "busRdData in reset", "R1");
    rstN = 1'b1;
    busCycle(12'h800, 0, 8'h00, "R1");

    // R6/R3: all pins input, pads read through the window
    padDrive = 8'hA5;
    repeat (3) busCycle(12'h800, 0, 8'h00, "R9");
    busCycle(12'h3FC, 0, 8'h00, "R6");
    busCycle(12'h3FF, 0, 8'h00, "R2");
    busCycle(12'h0C0, 0, 8'h00, "R3");

    // R5: direction register
    busCycle(12'h400, 1, 8'h0F, "R5");
    busCycle(12'h400, 0, 8'h00, "R5");

    // R4/R6: full and single-pin writes
    busCycle(12'h3FC, 1, 8'h3C, "R4");
    busCycle(12'h3FC, 0, 8'h00, "R6");
    busCycle(12'h010, 1, 8'h00, "R4");
    busCycle(12'h004, 1, 8'hFF, "R4");
    busCycle(12'h00C, 0, 8'h00, "R3");
    busCycle(12'h000, 1, 8'hFF, "R4");
    busCycle(12'h000, 0, 8'h00, "R3");
    busCycle(12'h003, 0, 8'h00, "R2");
    busCycle(12'h2AA, 1, 8'h55, "R2");

    // R8: write to an input pin, then enable it
    busCycle(12'h200, 1, 8'h80, "R8");
    busCycle(12'h3FC, 0, 8'h00, "R8");
    busCycle(12'h400, 1, 8'hFF, "R8");
    busCycle(12'h3FC, 0, 8'h00, "R8");

    // R9: reserved and unassigned addresses
    busCycle(12'h404, 1, 8'h00, "R9");
    busCycle(12'h404, 0, 8'h00, "R9");
    busCycle(12'h7FC, 1, 8'h00, "R9");
    busCycle(12'hC00, 1, 8'h12, "R9");
    busCycle(12'h401, 1, 8'h00, "R9");

    // R10: read and write in the same cycle return pre-write data
    busCycle(12'h3FC, 1, 8'h00, "R10");
    busCycle(12'h3FC, 1, 8'hF0, "R10");
    busCycle(12'h3FC, 0, 8'h00, "R10");

    // R7: synchronizer latency, all pins inputs
    busCycle(12'h400, 1, 8'h00, "R7");
    padDrive = 8'h00;
    repeat (3) busCycle(12'h3FC, 0, 8'h00, "R7");
    padDrive = 8'hFF;
    busCycle(12'h3FC, 0, 8'h00, "R7");   // expect 0x00 after edge k
    busCycle(12'h3FC, 0, 8'h00, "R7");   // expect 0x00 after edge k+1
    busCycle(12'h3FC, 0, 8'h00, "R7");   // expect 0xFF after edge k+2
    padDrive = 8'h3C;
    repeat (4) busCycle(12'h0F0, 0, 8'h00, "R7");

    busCycle(12'h800, 0, 8'h00, "R9");
    repeat (2) @(posedge clk);
    finishRun();
  end
endmodule